// File: doc/BRIEF.md
# Memory-Mapped SPI Boot ROM Bridge

This block lets a parallel host bus read a boot ROM held in a small serial SPI flash. Each host access that targets the ROM window is turned into one complete bit-banged SPI transaction. For an ordinary read, the block sends the read opcode 0x03 and a 24-bit byte address taken from the host address. It then clocks in one data byte and returns it on the parallel data bus. The host acknowledge stays low until the last bit has been captured.

The top eight bytes of the 2 MB window form a command window. There, software can shift raw opcode bytes into the flash and read back what the flash returns. Chip select stays asserted from one command access to the next, so multi-byte commands such as identification or erase can be built up one byte per bus cycle. A dedicated release write ends the sequence. A strap input selects parallel-ROM mode. In that mode chip select, the serial clock and MOSI all float, so an external programmer can drive the flash directly.

Top module: `spi_rom_bridge`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `spi_cs_n` is 1, `spi_sck` is 0 and `bus_ack` is 0.
- R2: A read at an address outside the command window produces exactly 40 SCK rising edges. MOSI carries 0x03, then the 24-bit byte address (the host address zero-extended), then eight ones, all MSB first. `spi_cs_n` is already low one full clock before the first rising edge.
- R3: The data byte is sampled from MISO on the last eight SCK pulses, MSB first, and is presented on `bus_rdata`. `bus_ack` rises 2*40+1 clock cycles after the strobe is first seen high.
- R4: The command window is selected when `bus_addr[20:3]` are all ones. Any other `bus_addr[20:3]` value is a data access, and this includes the addresses just below the window.
- R5: A command-window access with `bus_addr[2:0]` not equal to 1 produces exactly 8 SCK pulses. A write shifts out `bus_wdata` and a read shifts out 0xFF. `bus_rdata` returns the 8 bits captured from MISO, and `bus_ack` rises 2*8+1 cycles after the strobe.
- R6: After a command access, `spi_cs_n` stays low across later command accesses until software writes to the command window with `bus_addr[2:0]` = 1. That write raises `spi_cs_n`, produces no SCK pulse and acknowledges one cycle after the strobe.
- R7: `spi_cs_n` returns high when a data read completes, in the same cycle that `bus_ack` rises.
- R8: `bus_ack` stays high for as long as `bus_sel` is held, and no new transfer begins until the strobe has been removed.
- R9: SCK runs at half the system clock, with each phase one cycle long. MOSI changes only while SCK is low.
- R10: With `par_mode` high, `spi_cs_n`, `spi_sck` and `spi_mosi` are high-impedance.
- R11: A write outside the command window is acknowledged one cycle after the strobe. It produces no SCK pulse and leaves `spi_cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | Parallel-ROM strap; floats the SPI outputs when high |
| bus_sel | input | 1 | Host strobe for an access in the ROM window |
| bus_wr | input | 1 | High for a host write |
| bus_addr | input | 21 | Byte address within the 2 MB ROM window |
| bus_wdata | input | 8 | Host write data (command byte) |
| bus_rdata | output | 8 | Byte returned to the host |
| bus_ack | output | 1 | Transfer acknowledge, held until the strobe drops |
| spi_cs_n | output | 1 | Flash chip select, active low, tri-state |
| spi_sck | output | 1 | Serial clock, tri-state |
| spi_mosi | output | 1 | Serial data to the flash, tri-state |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses the default parameters: a 21-bit host address, a 24-bit flash address and 8-bit data. These values give the exact 40-pulse and 8-pulse frame lengths, so the 81-cycle and 17-cycle acknowledge latencies can be checked precisely. They also put the command window at 0x1FFFF8, so addresses that differ from it in a single bit (bit 3 or bit 20) can be tried to probe the decode boundary. The flash model in the bench answers the 0x03 read with an address-derived byte and answers an identification opcode across several held-select command accesses. This makes the chip-select hold and release sequence observable at the pins.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_ACK
  } bridge_state_t;

endpackage

// File: rtl/spi_rom_decode.sv
module spi_rom_decode #(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              is_cmd,
  output logic              is_release,
  output logic              is_dwrite
);

  localparam int SLOT_W = 3;

  always_comb begin
    is_cmd     = &addr[ADDR_W-1:SLOT_W];
    is_release = is_cmd && wr && (addr[SLOT_W-1:0] == SLOT_W'(1));
    is_dwrite  = !is_cmd && wr;
  end

endmodule

// File: rtl/spi_rom_shifter.sv
module spi_rom_shifter #(
  parameter int FRAME_W = 40,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CNT_W-1:0]   load_cnt,
  input  logic               sample,
  input  logic               advance,
  input  logic               miso,
  output logic               mosi,
  output logic [DATA_W-1:0]  rx_next,
  output logic               last
);

  logic [FRAME_W-2:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      mosi  <= 1'b0;
    end else if (load) begin
      mosi  <= load_frame[FRAME_W-1];
      tx_q  <= load_frame[FRAME_W-2:0];
      cnt_q <= load_cnt;
    end else begin
      if (sample) begin
        rx_q  <= rx_next;
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (advance) begin
        mosi <= tx_q[FRAME_W-2];
        tx_q <= {tx_q[FRAME_W-3:0], 1'b1};
      end
    end
  end

  always_comb begin
    rx_next = {rx_q[DATA_W-2:0], miso};
    last    = (cnt_q == CNT_W'(1));
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_W));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    sample |-> cnt_q != '0);

endmodule

// File: rtl/spi_rom_bridge.sv
module spi_rom_bridge
  import spi_rom_pkg::*;
#(
  parameter int         ADDR_W   = 21,
  parameter int         FLASH_AW = 24,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] READ_OP  = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int FRAME_W = DATA_W + FLASH_AW + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  bridge_state_t       st_q;
  logic                sck_q, cs_n_q, ack_q, cur_read_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                is_cmd, is_release, is_dwrite;
  logic                load, sample, advance, last, mosi_w;
  logic [DATA_W-1:0]   rx_next, cmd_byte;
  logic [FLASH_AW-1:0] flash_addr;
  logic [FRAME_W-1:0]  load_frame;
  logic [CNT_W-1:0]    load_cnt;

  spi_rom_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .is_cmd     (is_cmd),
    .is_release (is_release),
    .is_dwrite  (is_dwrite)
  );

  always_comb begin
    flash_addr = FLASH_AW'(bus_addr);
    cmd_byte   = bus_wr ? bus_wdata : '1;
    if (is_cmd) begin
      load_frame = {cmd_byte, {(FRAME_W-DATA_W){1'b1}}};
      load_cnt   = CNT_W'(DATA_W);
    end else begin
      load_frame = {READ_OP, flash_addr, {DATA_W{1'b1}}};
      load_cnt   = CNT_W'(FRAME_W);
    end
    load    = (st_q == ST_IDLE) && bus_sel && !is_release && !is_dwrite;
    sample  = (st_q == ST_HIGH);
    advance = sample && !last;
  end

  spi_rom_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_frame (load_frame),
    .load_cnt   (load_cnt),
    .sample     (sample),
    .advance    (advance),
    .miso       (spi_miso),
    .mosi       (mosi_w),
    .rx_next    (rx_next),
    .last       (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      ack_q      <= 1'b0;
      cur_read_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (bus_sel) begin
            if (is_release) begin
              cs_n_q <= 1'b1;
              ack_q  <= 1'b1;
              st_q   <= ST_ACK;
            end else if (is_dwrite) begin
              ack_q <= 1'b1;
              st_q  <= ST_ACK;
            end else begin
              cs_n_q     <= 1'b0;
              sck_q      <= 1'b0;
              cur_read_q <= !is_cmd;
              st_q       <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          sck_q <= 1'b1;
          st_q  <= ST_HIGH;
        end
        ST_HIGH: begin
          sck_q <= 1'b0;
          if (last) begin
            ack_q   <= 1'b1;
            rdata_q <= rx_next;
            if (cur_read_q) cs_n_q <= 1'b1;
            st_q <= ST_ACK;
          end else begin
            st_q <= ST_LOW;
          end
        end
        ST_ACK: begin
          if (!bus_sel) begin
            ack_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign spi_sck   = par_mode ? 1'bz : sck_q;
  assign spi_cs_n  = par_mode ? 1'bz : cs_n_q;
  assign spi_mosi  = par_mode ? 1'bz : mosi_w;

  assert_cs_leads_clock_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |-> !cs_n_q && $past(!cs_n_q));

  assert_ack_quiet_clock_R3: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> !sck_q);

  assert_read_releases_cs_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_q && cur_read_q) |-> cs_n_q);

  assert_ack_held_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_q && bus_sel) |=> ack_q);

  assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !sck_q);

  assert_mosi_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> $stable(mosi_w));

  assert_half_rate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |=> $fell(sck_q));

endmodule

// File: tb/sim_spi_rom_bridge.sv
`timescale 1ns/100ps
module sim_spi_rom_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        par_mode = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ack;
  wire         spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  spi_rom_bridge u0 (
    .clk(clk), .rst(rst), .par_mode(par_mode),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------- flash model ----------
  int          bitn = 0;
  int          rises = 0;
  logic [7:0]  opc = '0;
  logic [23:0] faddr = '0;
  logic [39:0] stream = '0;
  bit          cs_bad = 0;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic model_bit(input int n);
    int b;
    int i;
    logic [7:0] v;
    b = n / 8;
    i = 7 - (n % 8);
    if (b == 0) return 1'b1;
    if (opc == 8'h03) begin
      if (b < 4) return 1'b1;
      v = mem_byte(faddr);
      return v[i];
    end
    if (opc == 8'h9F) begin
      case (b)
        1: v = 8'hEF;
        2: v = 8'h30;
        3: v = 8'h13;
        default: v = 8'h00;
      endcase
      return v[i];
    end
    return 1'b0;
  endfunction

  always @(negedge spi_cs_n) begin
    bitn = 0;
    opc = '0;
    spi_miso = 1'b1;
  end

  always @(posedge spi_sck) begin
    stream = {stream[38:0], spi_mosi};
    bitn++;
    rises++;
    if (spi_cs_n !== 1'b0) cs_bad = 1;
    if (bitn == 8) opc = stream[7:0];
    if (bitn == 32) faddr = stream[23:0];
  end

  always @(negedge spi_sck) spi_miso = model_bit(bitn);

  // ---------- helpers ----------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [20:0] a, input logic [7:0] wd,
                        input int extra, output logic [7:0] rd, output int lat,
                        output bit ack_dropped);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rises = 0; lat = 0; cs_bad = 0; ack_dropped = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ack && lat < 500);
    rd = bus_rdata;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      if (!bus_ack) ack_dropped = 1;
    end
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam logic [20:0] VEC_ADDR [NV] = '{
    21'h000000, 21'h1FFFF7, 21'h0ABCDE, 21'h1FFFEF, 21'h155555, 21'h0FFFF8
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int lat;
    bit dropped;

    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", spi_cs_n, 1'b1);
    chk("R1 sck in reset", spi_sck, 1'b0);
    chk("R1 ack in reset", bus_ack, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after reset", spi_cs_n, 1'b1);
    chk("R1 ack after reset", bus_ack, 1'b0);

    // table-driven data reads (R2 R3 R4 R7)
    for (int i = 0; i < NV; i++) begin
      access(1'b0, VEC_ADDR[i], 8'h00, 0, rd, lat, dropped);
      chk("R3 read data", rd, mem_byte({3'b000, VEC_ADDR[i]}));
      chk("R3 ack latency", lat, 81);
      chk("R4 data window pulse count", rises, 40);
      chk("R2 frame on mosi", stream, {8'h03, 3'b000, VEC_ADDR[i], 8'hFF});
      chk("R2 cs active before clock", cs_bad, 1'b0);
      chk("R7 cs released after read", spi_cs_n, 1'b1);
    end

    // R8: hold strobe after ack
    access(1'b0, 21'h012345, 8'h00, 12, rd, lat, dropped);
    chk("R8 ack held with strobe", dropped, 1'b0);
    chk("R8 no second transfer", rises, 40);
    chk("R8 data while held", rd, mem_byte(24'h012345));

    // command sequence (R5 R6)
    access(1'b1, 21'h1FFFF8, 8'h9F, 0, rd, lat, dropped);
    chk("R5 cmd pulse count", rises, 8);
    chk("R5 cmd ack latency", lat, 17);
    chk("R5 cmd byte on mosi", stream[7:0], 8'h9F);
    chk("R5 cmd readback during opcode", rd, 8'hFF);
    chk("R6 cs held after cmd", spi_cs_n, 1'b0);
    access(1'b1, 21'h1FFFFA, 8'h00, 0, rd, lat, dropped);
    chk("R5 id byte 1", rd, 8'hEF);
    chk("R6 cs still held", spi_cs_n, 1'b0);
    access(1'b0, 21'h1FFFF8, 8'h00, 0, rd, lat, dropped);
    chk("R5 cmd read shifts ones", stream[7:0], 8'hFF);
    chk("R5 id byte 2", rd, 8'h30);
    access(1'b1, 21'h1FFFFF, 8'h00, 0, rd, lat, dropped);
    chk("R5 id byte 3", rd, 8'h13);
    access(1'b1, 21'h1FFFF9, 8'h00, 0, rd, lat, dropped);
    chk("R6 release latency", lat, 1);
    chk("R6 release no clocks", rises, 0);
    chk("R6 cs released", spi_cs_n, 1'b1);

    // R11: data write ignored
    access(1'b1, 21'h000100, 8'hA5, 0, rd, lat, dropped);
    chk("R11 write latency", lat, 1);
    chk("R11 write no clocks", rises, 0);
    chk("R11 cs stays high", spi_cs_n, 1'b1);

    // R4 boundary: bit 20 clear, low bits all set -> data read
    access(1'b0, 21'h0FFFFF, 8'h00, 0, rd, lat, dropped);
    chk("R4 below window is data", rises, 40);

    // R10: parallel ROM mode
    @(negedge clk);
    par_mode = 1'b1;
    @(negedge clk);
    chk("R10 sck floats", spi_sck === 1'bz, 1'b1);
    chk("R10 mosi floats", spi_mosi === 1'bz, 1'b1);
    chk("R10 cs floats", spi_cs_n === 1'bz, 1'b1);
    par_mode = 1'b0;
    @(negedge clk);
    chk("R10 cs driven again", spi_cs_n, 1'b1);

    // R1: reset mid-transfer
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 21'h000040;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R1 cs_n after mid reset", spi_cs_n, 1'b1);
    chk("R1 sck after mid reset", spi_sck, 1'b0);
    chk("R1 ack after mid reset", bus_ack, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule